// File: doc/BRIEF.md
# Dual-Address Paged Management Register Map

This block is the byte-level back end of a two-wire management slave in a pluggable optical module. A serial front end, not part of this block, does the bit-level work and passes decoded transactions in. It opens a transaction with a device address and a starting byte offset. It then issues write strobes carrying a data byte, or read strobes. The block answers two device addresses. Address 0xA0 serves the basic and transmit-side functions. Address 0xA8 serves the optional extensions, including receive-side data.

Each address has a 256-byte window. Offsets 0 to 127 reach a lower page that belongs to that address alone. The lower page holds live monitor bytes taken from input ports, a bank of read-write control bytes, and a page-select byte. Offsets 128 to 255 reach the upper region. Upper page 00h is read-only and holds the same content through both addresses. When paging is built in, each address can switch its upper region to its own read-only page 01h.

A byte pointer is loaded when a transaction opens. It steps by one after every accepted read or write, and it wraps from 255 back to 128 so that sequential reads cycle through the upper page.

A three-state session machine decides which address is being served:
- SESS_IDLE: no session is open.
- SESS_BASE: a session on address 0xA0 is open.
- SESS_EXT: a session on address 0xA8 is open.

Its transitions are:
- OPEN_BASE: a transaction start naming 0xA0 moves to SESS_BASE.
- OPEN_EXT: a transaction start naming 0xA8 moves to SESS_EXT.
- OPEN_MISS: a transaction start naming any other address moves to SESS_IDLE.
- CLOSE: a stop moves from SESS_BASE or SESS_EXT to SESS_IDLE.

A transaction start may be taken from any state, and it wins over a stop in the same cycle.

Top module: `mmap_regmap`

## Requirements
- R1: After reset, rd_valid_o and rd_data_o are 0, no session is open, every control byte of both addresses reads 0x00, and both page selects read 0x00.
- R2: A transaction start with address 0xA0 opens the base session and one with 0xA8 opens the extension session. Any other address, and a stop, leaves no session open. Read and write strobes with no session open, or in the same cycle as a transaction start, have no effect: no rd_valid_o and no stored byte change.
- R3: An accepted read strobe raises rd_valid_o for exactly the next cycle, with rd_data_o equal to the byte at the pointer at the time of the strobe.
- R4: The pointer is loaded from offset_i when a transaction starts. It advances by one after each accepted read or write, and it goes from 255 to 128.
- R5: Upper page 00h byte at offset 128+k reads (3k + 0x11) mod 256, and it reads the same through 0xA0 and 0xA8.
- R6: With paging built in and page 01h selected, offset 128+k reads k XOR 0xA0 through 0xA0 and k XOR 0xA8 through 0xA8.
- R7: Lower offset 127 of each address is its page select. Writing 0x01 selects page 01h only when paging is built in. Every other value, or any value in a build without paging, selects 00h. The byte reads back 0x00 or 0x01. The select of one address has no effect on the other.
- R8: Writes to offsets 128 to 255 change no byte that reads back.
- R9: The monitor bytes read the live inputs at the time of the read strobe and ignore writes. Through 0xA0: offset 0 is the transmit flags, offsets 1 and 2 are temperature high and low, and offsets 3 and 4 are supply high and low. Through 0xA8: offset 0 is the receive flags, and offsets 1 and 2 are receive power high and low.
- R10: Lower offsets 16 to 23 are read-write control bytes, separate for each address.
- R11: All other lower offsets read 0x00, and writes to them are ignored.
- R12: A read and a write strobe in the same cycle return the byte as it was before the write, store the write, and advance the pointer once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start_i | input | 1 | Opens a transaction with dev_addr_i and offset_i |
| dev_addr_i | input | 8 | Device address of the transaction |
| offset_i | input | 8 | Starting byte offset |
| stop_i | input | 1 | Closes the current session |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Read strobe |
| tx_flags_i | input | 8 | Transmit flag byte |
| temp_i | input | 16 | Temperature monitor |
| supply_i | input | 16 | Supply voltage monitor |
| rx_flags_i | input | 8 | Receive flag byte |
| rx_power_i | input | 16 | Receive power monitor |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a read strobe and a write strobe. The bench raises both in one cycle on a control byte whose value it already knows. It expects the old value on rd_data_o. It then expects the following byte on the next read, which shows that the pointer advanced only once. A fresh transaction at the same offset must then return the new value.

The second pair is a transaction start and a read strobe. The bench raises them together and expects no rd_valid_o. The next read must return the byte at the newly loaded offset, not one past it.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam logic [7:0] DEV_ADDR_BASE = 8'hA0;
    localparam logic [7:0] DEV_ADDR_EXT  = 8'hA8;

    typedef enum logic [1:0] {
        SESS_IDLE = 2'd0,
        SESS_BASE = 2'd1,
        SESS_EXT  = 2'd2
    } sess_t;

    // Shared read-only upper page 00h content, indexed within the page
    function automatic logic [7:0] upper_p0_byte(input logic [6:0] idx);
        logic [7:0] w;
        w = {1'b0, idx};
        return 8'((w * 8'd3) + 8'h11);
    endfunction

    // Per-address read-only upper page 01h content
    function automatic logic [7:0] upper_p1_byte(input logic ext, input logic [6:0] idx);
        return {1'b0, idx} ^ (ext ? DEV_ADDR_EXT : DEV_ADDR_BASE);
    endfunction

endpackage

// File: rtl/mmap_sess_fsm.sv
module mmap_sess_fsm
    import mmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start_i,
    input  logic [7:0] dev_addr_i,
    input  logic       stop_i,
    output logic       active_o,
    output logic       ext_o
);

    sess_t state_q, state_d, open_tgt;

    always_comb begin
        if (dev_addr_i == DEV_ADDR_BASE)     open_tgt = SESS_BASE;
        else if (dev_addr_i == DEV_ADDR_EXT) open_tgt = SESS_EXT;
        else                                 open_tgt = SESS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SESS_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: OPEN_BASE / OPEN_EXT / OPEN_MISS from any state, CLOSE on stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SESS_IDLE: begin
                if (txn_start_i) state_d = open_tgt;
            end
            SESS_BASE, SESS_EXT: begin
                if (txn_start_i) state_d = open_tgt;
                else if (stop_i) state_d = SESS_IDLE;
            end
            default: state_d = SESS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SESS_IDLE: begin active_o = 1'b0; ext_o = 1'b0; end
            SESS_BASE: begin active_o = 1'b1; ext_o = 1'b0; end
            SESS_EXT:  begin active_o = 1'b1; ext_o = 1'b1; end
            default:   begin active_o = 1'b0; ext_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/mmap_ptr.sv
module mmap_ptr #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFF_W-1:0] load_off_i,
    input  logic             step_i,
    output logic [OFF_W-1:0] ptr_o
);

    localparam logic [OFF_W-1:0] PTR_TOP  = {OFF_W{1'b1}};
    localparam logic [OFF_W-1:0] PTR_WRAP = {1'b1, {(OFF_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (load_i)
            ptr_o <= load_off_i;
        else if (step_i)
            ptr_o <= (ptr_o == PTR_TOP) ? PTR_WRAP : ptr_o + 1'b1;
    end

endmodule

// File: rtl/mmap_lower.sv
module mmap_lower #(
    parameter bit PAGING_EN = 1'b1,
    parameter int NUM_CTRL  = 8,
    parameter int CTRL_BASE = 16,
    parameter int NUM_MON   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [6:0]           off_i,
    input  logic [7:0]           wdata_i,
    input  logic [NUM_MON*8-1:0] mon_i,
    output logic [7:0]           rdata_o,
    output logic                 psel_o
);

    localparam logic [6:0] PSEL_OFF = 7'h7F;

    logic [NUM_CTRL-1:0][7:0] ctrl_q;
    logic                     psel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            for (int j = 0; j < NUM_CTRL; j++)
                if (off_i == 7'(CTRL_BASE + j)) ctrl_q[j] <= wdata_i;
        end
    end

    if (PAGING_EN) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                psel_q <= 1'b0;
            else if (wr_en_i && off_i == PSEL_OFF)
                psel_q <= (wdata_i == 8'h01);
        end
    end else begin : g_nopage
        assign psel_q = 1'b0;
    end

    assign psel_o = psel_q;

    always_comb begin
        rdata_o = 8'h00;
        if (off_i == PSEL_OFF) rdata_o = {7'd0, psel_q};
        for (int i = 0; i < NUM_MON; i++)
            if (off_i == 7'(i)) rdata_o = mon_i[i*8 +: 8];
        for (int j = 0; j < NUM_CTRL; j++)
            if (off_i == 7'(CTRL_BASE + j)) rdata_o = ctrl_q[j];
    end

endmodule

// File: rtl/mmap_regmap.sv
module mmap_regmap
    import mmap_pkg::*;
#(
    parameter bit PAGING_EN = 1'b1,
    parameter int NUM_CTRL  = 8,
    parameter int CTRL_BASE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_start_i,
    input  logic [7:0]  dev_addr_i,
    input  logic [7:0]  offset_i,
    input  logic        stop_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_data_i,
    input  logic        rd_en_i,
    input  logic [7:0]  tx_flags_i,
    input  logic [15:0] temp_i,
    input  logic [15:0] supply_i,
    input  logic [7:0]  rx_flags_i,
    input  logic [15:0] rx_power_i,
    output logic [7:0]  rd_data_o,
    output logic        rd_valid_o
);

    localparam int NUM_MON = 5;
    localparam int MON_W   = NUM_MON * 8;
    localparam int NUM_DEV = 2;

    logic                           active, ext, accept, step;
    logic [7:0]                     ptr, cur_byte;
    logic [NUM_DEV-1:0][MON_W-1:0]  mon_vec;
    logic [NUM_DEV-1:0][7:0]        lo_rdata;
    logic [NUM_DEV-1:0]             psel, lo_wr;

    mmap_sess_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start_i (txn_start_i),
        .dev_addr_i  (dev_addr_i),
        .stop_i      (stop_i),
        .active_o    (active),
        .ext_o       (ext)
    );

    assign accept = active && !txn_start_i;
    assign step   = accept && (rd_en_i || wr_en_i);

    mmap_ptr #(.OFF_W(8)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (txn_start_i),
        .load_off_i (offset_i),
        .step_i     (step),
        .ptr_o      (ptr)
    );

    // Monitor byte order within each lower page: byte 0 first
    assign mon_vec[0] = {supply_i[7:0], supply_i[15:8], temp_i[7:0], temp_i[15:8], tx_flags_i};
    assign mon_vec[1] = {16'h0000, rx_power_i[7:0], rx_power_i[15:8], rx_flags_i};

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign lo_wr[g] = accept && wr_en_i && !ptr[7] && (ext == (g == 1));

        mmap_lower #(
            .PAGING_EN (PAGING_EN),
            .NUM_CTRL  (NUM_CTRL),
            .CTRL_BASE (CTRL_BASE),
            .NUM_MON   (NUM_MON)
        ) u_lower (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (lo_wr[g]),
            .off_i   (ptr[6:0]),
            .wdata_i (wr_data_i),
            .mon_i   (mon_vec[g]),
            .rdata_o (lo_rdata[g]),
            .psel_o  (psel[g])
        );
    end

    always_comb begin
        if (!ptr[7])        cur_byte = lo_rdata[ext];
        else if (psel[ext]) cur_byte = upper_p1_byte(ext, ptr[6:0]);
        else                cur_byte = upper_p0_byte(ptr[6:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= 8'h00;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= accept && rd_en_i;
            if (accept && rd_en_i) rd_data_o <= cur_byte;
        end
    end

endmodule

// File: rtl/mmap_regmap_chk.sv
module mmap_regmap_chk
    import mmap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       txn_start_i,
    input logic [7:0] dev_addr_i,
    input logic       stop_i,
    input logic       rd_en_i,
    input logic       wr_en_i,
    input logic       rd_valid_o,
    input logic       active,
    input logic       ext,
    input logic [7:0] ptr,
    input logic [1:0] psel
);

    assert_valid_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_en_i && active && !txn_start_i));

    assert_open_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start_i && dev_addr_i == DEV_ADDR_EXT) |=> (active && ext));

    assert_open_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start_i && dev_addr_i == DEV_ADDR_BASE) |=> (active && !ext));

    assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !txn_start_i) |=> !active);

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rd_valid_o);

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !txn_start_i && (rd_en_i || wr_en_i) && ptr == 8'hFF) |=> (ptr == 8'h80));

    assert_psel_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(psel) |-> $past(wr_en_i && active && !txn_start_i && ptr == 8'h7F));

endmodule

bind mmap_regmap mmap_regmap_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start_i (txn_start_i),
    .dev_addr_i  (dev_addr_i),
    .stop_i      (stop_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .rd_valid_o  (rd_valid_o),
    .active      (active),
    .ext         (ext),
    .ptr         (ptr),
    .psel        (psel)
);

// File: tb/mmap_regmap_tb.sv
module mmap_regmap_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0, stop = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  dev_addr = 8'h00, offset = 8'h00, wr_data = 8'h00;
    logic [7:0]  tx_flags = 8'h5A, rx_flags = 8'hC3;
    logic [15:0] temp = 16'h1234, supply = 16'h8ABC, rx_power = 16'h0F1E;
    logic [7:0]  rd_data, np_rd_data;
    logic        rd_valid, np_rd_valid;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmap_regmap u_dut (
        .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start), .dev_addr_i(dev_addr),
        .offset_i(offset), .stop_i(stop), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .tx_flags_i(tx_flags), .temp_i(temp), .supply_i(supply),
        .rx_flags_i(rx_flags), .rx_power_i(rx_power),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid)
    );

    mmap_regmap #(.PAGING_EN(1'b0)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start), .dev_addr_i(dev_addr),
        .offset_i(offset), .stop_i(stop), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .tx_flags_i(tx_flags), .temp_i(temp), .supply_i(supply),
        .rx_flags_i(rx_flags), .rx_power_i(rx_power),
        .rd_data_o(np_rd_data), .rd_valid_o(np_rd_valid)
    );

    function automatic logic [7:0] exp_p0(input int k);
        return 8'((3 * k + 17) % 256);
    endfunction

    function automatic logic [7:0] exp_p1(input bit ext, input int k);
        return 8'(k) ^ (ext ? 8'hA8 : 8'hA0);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic open_txn(input logic [7:0] dev, input logic [7:0] off);
        @(negedge clk);
        txn_start = 1'b1; dev_addr = dev; offset = off;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read and check the main DUT; valid must be raised
    task automatic rd_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " valid"}, {7'd0, rd_valid}, 8'h01);
        check(tag, rd_data, exp);
    endtask

    // read and check both DUTs
    task automatic rd_both(input string tag, input logic [7:0] exp, input logic [7:0] exp_np);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp);
        check({tag, " no-paging"}, np_rd_data, exp_np);
    endtask

    task automatic rd_none(input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {7'd0, rd_valid}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        check("R1 rd_data in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        rd_none("R1 no session after reset");
        for (int d = 0; d < 2; d++) begin
            open_txn(d == 0 ? 8'hA0 : 8'hA8, 8'd16);
            for (int j = 0; j < 8; j++) rd_chk("R1 control byte reset", 8'h00);
            open_txn(d == 0 ? 8'hA0 : 8'hA8, 8'd127);
            rd_chk("R1 page select reset", 8'h00);
        end

        // R2: unknown address, stop, start with strobe
        open_txn(8'h50, 8'd16);
        wr_byte(8'h77);
        rd_none("R2 read on unknown address");
        open_txn(8'hA0, 8'd16);
        rd_chk("R2 idle write ignored", 8'h00);
        open_txn(8'hA0, 8'd16);
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
        rd_none("R2 read after stop");
        @(negedge clk);
        txn_start = 1'b1; dev_addr = 8'hA0; offset = 8'd1; rd_en = 1'b1;
        @(negedge clk);
        txn_start = 1'b0; rd_en = 1'b0;
        check("R2 strobe with start ignored", {7'd0, rd_valid}, 8'h00);
        rd_chk("R2 R4 pointer loaded not stepped", temp[15:8]);

        // R9: monitor bytes through 0xA0, live and write-proof
        for (int pass = 0; pass < 2; pass++) begin
            open_txn(8'hA0, 8'd0);
            rd_chk("R9 tx flags", tx_flags);
            rd_chk("R9 temp hi", temp[15:8]);
            rd_chk("R9 temp lo", temp[7:0]);
            rd_chk("R9 supply hi", supply[15:8]);
            rd_chk("R9 supply lo", supply[7:0]);
            rd_chk("R11 offset 5 zero", 8'h00);
            tx_flags = 8'hA5; temp = 16'hFEDC; supply = 16'h3141;
        end
        open_txn(8'hA0, 8'd0);
        for (int i = 0; i < 5; i++) wr_byte(8'hFF);
        open_txn(8'hA0, 8'd0);
        rd_chk("R9 write ignored flags", tx_flags);
        rd_chk("R9 write ignored temp hi", temp[15:8]);
        open_txn(8'hA8, 8'd0);
        rd_chk("R9 rx flags", rx_flags);
        rd_chk("R9 rx power hi", rx_power[15:8]);
        rd_chk("R9 rx power lo", rx_power[7:0]);
        rd_chk("R11 ext offset 3 zero", 8'h00);

        // R10: control bytes per address
        open_txn(8'hA0, 8'd16);
        for (int j = 0; j < 8; j++) wr_byte(8'(j * 17 + 3));
        open_txn(8'hA8, 8'd16);
        for (int j = 0; j < 8; j++) wr_byte(8'(240 - j));
        open_txn(8'hA0, 8'd16);
        for (int j = 0; j < 8; j++) rd_chk("R10 base control", 8'(j * 17 + 3));
        open_txn(8'hA8, 8'd16);
        for (int j = 0; j < 8; j++) rd_chk("R10 ext control", 8'(240 - j));

        // R11: unimplemented lower bytes
        open_txn(8'hA0, 8'd5);
        for (int o = 5; o < 16; o++) wr_byte(8'hEE);
        open_txn(8'hA0, 8'd24);
        for (int o = 24; o < 127; o++) wr_byte(8'hEE);
        open_txn(8'hA0, 8'd5);
        for (int o = 5; o < 16; o++) rd_chk("R11 unimplemented low", 8'h00);
        open_txn(8'hA0, 8'd24);
        for (int o = 24; o < 127; o++) rd_chk("R11 unimplemented high", 8'h00);

        // R5: shared upper page 00h through both addresses
        for (int d = 0; d < 2; d++) begin
            open_txn(d == 0 ? 8'hA0 : 8'hA8, 8'd128);
            for (int k = 0; k < 128; k++) rd_both("R5 upper page 00h", exp_p0(k), exp_p0(k));
        end

        // R8: writes to the upper region change nothing
        open_txn(8'hA0, 8'd128);
        for (int k = 0; k < 128; k++) wr_byte(8'(k) ^ 8'hFF);
        open_txn(8'hA0, 8'd128);
        for (int k = 0; k < 128; k++) rd_chk("R8 upper write ignored", exp_p0(k));

        // R7/R6/R4: select page 01h on 0xA0, sweep with wrap
        open_txn(8'hA0, 8'd127);
        wr_byte(8'h01);
        open_txn(8'hA0, 8'd127);
        rd_both("R7 select readback", 8'h01, 8'h00);
        for (int k = 0; k < 130; k++)
            rd_both("R6 R4 page 01h sweep with wrap", exp_p1(1'b0, k % 128), exp_p0(k % 128));
        open_txn(8'hA8, 8'd128);
        for (int k = 0; k < 4; k++) rd_chk("R7 other address unaffected", exp_p0(k));
        open_txn(8'hA8, 8'd127);
        wr_byte(8'h01);
        open_txn(8'hA8, 8'd128);
        for (int k = 0; k < 128; k++) rd_both("R6 ext page 01h", exp_p1(1'b1, k), exp_p0(k));
        open_txn(8'hA0, 8'd127);
        wr_byte(8'h02);
        open_txn(8'hA0, 8'd127);
        rd_chk("R7 unsupported page reads 00h", 8'h00);
        rd_chk("R7 unsupported page serves 00h", exp_p0(0));
        open_txn(8'hA0, 8'd126);
        rd_chk("R4 step across boundary 126", 8'h00);
        rd_chk("R4 step across boundary 127", 8'h00);
        rd_chk("R4 step across boundary 128", exp_p0(0));

        // R12: read and write in the same cycle
        open_txn(8'hA0, 8'd17);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R12 read returns old byte", rd_data, 8'(1 * 17 + 3));
        rd_chk("R12 pointer stepped once", 8'(2 * 17 + 3));
        open_txn(8'hA0, 8'd17);
        rd_chk("R12 write stored", 8'h3C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule